// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block runs the stack part of a subroutine call and of a subroutine return. A call command pushes the current program counter onto a user stack and then redirects the program counter to a target address. The target address is computed elsewhere and arrives as an input. A return command pops the saved word and restores the program counter from it. The stack lives in memory. The block addresses it with the stack segment value as the segment and a stack pointer that it owns as the offset.

A push decrements the pointer before the address is formed. A pop forms the address from the pointer and then increments it. Each command moves exactly one word: the return address. Memory is reached through a request/acknowledge handshake. The sequencer holds its request, with a stable address and stable write data, until the acknowledge arrives. A one-cycle done pulse marks the cycle in which the new program counter is visible.

The stack pointer takes an initial value through a load input while the sequencer is idle.

Top module: `cret_seq_top`

## Requirements
- R1: A call writes at offset SP-1 (modulo 2^W) and leaves SP at that value, including the wrap from 0 to all ones.
- R2: The word a call writes is the PC value presented with the start command. The segment it presents is the SS value presented with the start command.
- R3: After its write is acknowledged, a call loads PC with the target input. With zero memory wait, done is high in the sixth falling clock edge counted from the edge on which start was driven.
- R4: A return reads at offset SP and leaves SP at SP+1 (modulo 2^W). The segment it presents is the SS value captured at start.
- R5: A return loads PC with the read data returned on the acknowledged cycle. With zero memory wait, done is high in the fifth falling edge counted as in R3.
- R6: Each command makes exactly one memory access, so nested calls come back in last-in-first-out order.
- R7: mem_req stays high with mem_off, mem_seg and mem_wdata unchanged until mem_ack. Each cycle of wait adds one cycle before done.
- R8: done is high for exactly one cycle, the cycle in which pc_out first shows the new value. mem_req is low in that cycle.
- R9: A start that arrives while busy is high is ignored. It causes no extra access and does not change the result of the command in progress.
- R10: After reset, pc_out is 0, sp_out is SP_RESET (default 0), and busy, done and mem_req are low.
- R11: A high sp_load while idle sets SP to sp_load_val on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| op_ret | input | 1 | 0 = call, 1 = return |
| pc_in | input | W | Current program counter (return address for a call) |
| target_in | input | W | Computed call target |
| ss_in | input | SW | Stack segment |
| sp_load | input | 1 | Load the stack pointer (idle only) |
| sp_load_val | input | W | Value for sp_load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seg | output | SW | Segment of the access |
| mem_off | output | W | Offset of the access |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | W | Read data, valid with mem_ack |
| sp_out | output | W | Current stack pointer |
| pc_out | output | W | Updated program counter |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Single call/return pairs with distinct PC, target and SS values separate the write data from the target. They also show whether the segment comes from the captured value. Two nested calls unwound by two returns, with a three-cycle memory wait, separate pre-decrement from post-decrement and LIFO order from FIFO order. The same run measures how the wait stretches completion. A call from SP=0 exercises the pointer wrap. A start injected mid-command shows whether the busy guard holds.

// File: rtl/cret_pkg.sv
// Package: shared state encoding and control bundle for the call/return
// stack sequencer. Assumes nothing beyond the modules that import it.
package cret_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEC  = 3'd1,
        ST_MAR  = 3'd2,
        ST_INC  = 3'd3,
        ST_MDR  = 3'd4,
        ST_MEM  = 3'd5,
        ST_PC   = 3'd6
    } seq_st_t;

    typedef struct packed {
        logic cap;         // capture command operands
        logic sp_dec;      // pre-decrement stack pointer
        logic sp_inc;      // post-increment stack pointer
        logic mar_ld;      // address register from stack pointer
        logic mdr_ld_pc;   // data register from captured PC
        logic mdr_ld_bus;  // data register from read bus
        logic pc_ld;       // program counter update
        logic pc_from_mdr; // PC source: 1 = data register, 0 = target
    } seq_ctl_t;

endpackage

// File: rtl/cret_ctrl.sv
// Module: cret_ctrl
// Micro-step controller. A call walks DEC, MAR, MDR, MEM, PC. A return
// walks MAR, INC, MEM, PC. It waits in MEM until the memory acknowledges.
// Assumes mem_ack is a single-cycle pulse that is only meaningful while
// a request is raised.
module cret_ctrl
    import cret_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     op_ret,
    input  logic     mem_ack,
    output seq_ctl_t ctl,
    output logic     mem_req,
    output logic     mem_we,
    output logic     busy
);

    seq_st_t st_q, st_d;
    logic    ret_q;

    // State register and latched command kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ret_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) ret_q <= op_ret;
        end
    end

    // Next-state and per-step control decode
    always_comb begin
        st_d    = st_q;
        ctl     = '0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.cap = 1'b1;
                    st_d    = op_ret ? ST_MAR : ST_DEC;
                end
            end
            ST_DEC: begin
                ctl.sp_dec = 1'b1;
                st_d       = ST_MAR;
            end
            ST_MAR: begin
                ctl.mar_ld = 1'b1;
                st_d       = ret_q ? ST_INC : ST_MDR;
            end
            ST_INC: begin
                ctl.sp_inc = 1'b1;
                st_d       = ST_MEM;
            end
            ST_MDR: begin
                ctl.mdr_ld_pc = 1'b1;
                st_d          = ST_MEM;
            end
            ST_MEM: begin
                mem_req = 1'b1;
                mem_we  = ~ret_q;
                if (mem_ack) begin
                    ctl.mdr_ld_bus = ret_q;
                    st_d           = ST_PC;
                end
            end
            ST_PC: begin
                ctl.pc_ld       = 1'b1;
                ctl.pc_from_mdr = ret_q;
                st_d            = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Busy whenever a command is under way
    always_comb busy = (st_q != ST_IDLE);

endmodule

// File: rtl/cret_sp_unit.sv
// Module: cret_sp_unit
// Stack pointer register. Supports an idle-time load, a decrement for a
// push and an increment for a pop. Arithmetic wraps modulo 2^W.
// Assumes the controller never asserts two of load/dec/inc together.
module cret_sp_unit #(
    parameter int          W        = 16,
    parameter logic [W-1:0] SP_RESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    input  logic         inc,
    output logic [W-1:0] sp
);

    localparam logic [W-1:0] ONE = W'(1);

    // Pointer update, load has lowest priority and only comes when idle
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_RESET;
        else if (dec) sp <= sp - ONE;
        else if (inc) sp <= sp + ONE;
        else if (ld)  sp <= ld_val;
    end

endmodule

// File: rtl/cret_xfer_path.sv
// Module: cret_xfer_path
// Datapath: operand capture, address register, data register, program
// counter and the done flag. Assumes control strobes come from cret_ctrl.
module cret_xfer_path
    import cret_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_ctl_t      ctl,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  target_in,
    input  logic [SW-1:0] ss_in,
    input  logic [W-1:0]  sp,
    input  logic [W-1:0]  rdata,
    output logic [SW-1:0] seg,
    output logic [W-1:0]  mar,
    output logic [W-1:0]  mdr,
    output logic [W-1:0]  pc,
    output logic          done
);

    logic [W-1:0] ret_addr_q, tgt_q;

    // Capture operands when a command is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr_q <= '0;
            tgt_q      <= '0;
            seg        <= '0;
        end else if (ctl.cap) begin
            ret_addr_q <= pc_in;
            tgt_q      <= target_in;
            seg        <= ss_in;
        end
    end

    // Address register follows the stack pointer on its step
    always_ff @(posedge clk) begin
        if (!rst_n)          mar <= '0;
        else if (ctl.mar_ld) mar <= sp;
    end

    // Data register: return address for a push, bus word for a pop
    always_ff @(posedge clk) begin
        if (!rst_n)              mdr <= '0;
        else if (ctl.mdr_ld_pc)  mdr <= ret_addr_q;
        else if (ctl.mdr_ld_bus) mdr <= rdata;
    end

    // Program counter update and the matching one-cycle done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            done <= 1'b0;
        end else begin
            done <= ctl.pc_ld;
            if (ctl.pc_ld) pc <= ctl.pc_from_mdr ? mdr : tgt_q;
        end
    end

endmodule

// File: rtl/cret_seq_top.sv
// Module: cret_seq_top
// Call/return stack sequencer top. It pushes or pops one return address
// on a memory stack addressed by SS:SP and then updates the PC.
// Assumes SS is valid at start and the target is computed outside.
module cret_seq_top
    import cret_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           SW       = 16,
    parameter logic [W-1:0] SP_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_ret,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  target_in,
    input  logic [SW-1:0] ss_in,
    input  logic          sp_load,
    input  logic [W-1:0]  sp_load_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [SW-1:0] mem_seg,
    output logic [W-1:0]  mem_off,
    output logic [W-1:0]  mem_wdata,
    input  logic          mem_ack,
    input  logic [W-1:0]  mem_rdata,
    output logic [W-1:0]  sp_out,
    output logic [W-1:0]  pc_out,
    output logic          busy,
    output logic          done
);

    seq_ctl_t ctl;
    logic     sp_ld_ok;

    // Pointer load is honoured only between commands
    always_comb sp_ld_ok = sp_load & ~busy;

    cret_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_ret  (op_ret),
        .mem_ack (mem_ack),
        .ctl     (ctl),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .busy    (busy)
    );

    cret_sp_unit #(.W(W), .SP_RESET(SP_RESET)) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (sp_ld_ok),
        .ld_val (sp_load_val),
        .dec    (ctl.sp_dec),
        .inc    (ctl.sp_inc),
        .sp     (sp_out)
    );

    cret_xfer_path #(.W(W), .SW(SW)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .pc_in     (pc_in),
        .target_in (target_in),
        .ss_in     (ss_in),
        .sp        (sp_out),
        .rdata     (mem_rdata),
        .seg       (mem_seg),
        .mar       (mem_off),
        .mdr       (mem_wdata),
        .pc        (pc_out),
        .done      (done)
    );

endmodule

// File: rtl/cret_seq_chk.sv
// Module: cret_seq_chk
// Protocol and ordering checker attached to cret_seq_top by bind.
// Assumes the port names of the top module.
module cret_seq_chk #(
    parameter int W  = 16,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [SW-1:0] mem_seg,
    input logic [W-1:0]  mem_off,
    input logic [W-1:0]  mem_wdata,
    input logic [W-1:0]  sp_out,
    input logic          busy,
    input logic          done
);

    localparam logic [W-1:0] ONE = W'(1);

    // R7: a pending request is held until acknowledged
    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R7: address, segment and data do not move while waiting
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_off) && $stable(mem_seg) && $stable(mem_wdata)));

    // R1: a push targets the already decremented pointer
    p_push_predec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> (mem_off == sp_out));

    // R4: a pop targets the pointer before its increment
    p_pop_postinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> (mem_off == sp_out - ONE));

    // R8: done lasts exactly one cycle and never overlaps a request
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R10: no memory activity while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind cret_seq_top cret_seq_chk #(.W(W), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_seg   (mem_seg),
    .mem_off   (mem_off),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_cret_seq_top.sv
module sim_cret_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_ret = 1'b0;
    logic [W-1:0]  pc_in = '0;
    logic [W-1:0]  target_in = '0;
    logic [SW-1:0] ss_in = '0;
    logic          sp_load = 1'b0;
    logic [W-1:0]  sp_load_val = '0;
    logic          mem_req, mem_we;
    logic [SW-1:0] mem_seg;
    logic [W-1:0]  mem_off, mem_wdata;
    logic          mem_ack = 1'b0;
    logic [W-1:0]  mem_rdata = '0;
    logic [W-1:0]  sp_out, pc_out;
    logic          busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    int mem_lat  = 0;
    int wait_cnt = 0;
    int acc_cnt  = 0;
    logic          last_we;
    logic [W-1:0]  last_off, last_data;
    logic [SW-1:0] last_seg;
    logic [W-1:0]  mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    cret_seq_top #(.W(W), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_ret(op_ret),
        .pc_in(pc_in), .target_in(target_in), .ss_in(ss_in),
        .sp_load(sp_load), .sp_load_val(sp_load_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
        .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .sp_out(sp_out), .pc_out(pc_out),
        .busy(busy), .done(done)
    );

    // Memory model: acknowledges after mem_lat waiting falling edges
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_ack   = 1'b1;
                wait_cnt  = 0;
                acc_cnt   = acc_cnt + 1;
                last_we   = mem_we;
                last_off  = mem_off;
                last_seg  = mem_seg;
                if (mem_we) begin
                    mem[mem_off[7:0]] = mem_wdata;
                    last_data = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_off[7:0]];
                    last_data = mem_rdata;
                end
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
    end

    task automatic load_sp(input logic [W-1:0] v);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    // Issue one command and return the falling edges until done
    task automatic run_cmd(input logic ret, input logic [W-1:0] pc, input logic [W-1:0] tgt,
                           input logic [SW-1:0] ss, output int cycles);
        @(negedge clk);
        start = 1'b1; op_ret = ret; pc_in = pc; target_in = tgt; ss_in = ss;
        @(negedge clk);
        start = 1'b0; pc_in = '0; target_in = '0; ss_in = '0;
        cycles = 1;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 0, "R10 pc", pc_out, 0);
        chk(sp_out == 0, "R10 sp", sp_out, 0);
        chk(!busy && !done && !mem_req, "R10 idle", {busy, done, mem_req}, 0);
        load_sp(16'h0100);
        chk(sp_out == 16'h0100, "R11 sp load", sp_out, 16'h0100);
    endtask

    task automatic t_call_ret;
        int cyc, a0;
        a0 = acc_cnt;
        mem_lat = 0;
        run_cmd(1'b0, 16'h1234, 16'hABCD, 16'h5A5A, cyc);
        chk(cyc == 6, "R3 call latency", cyc, 6);
        chk(last_we == 1'b1 && last_off == 16'h00FF, "R1 push offset", last_off, 16'h00FF);
        chk(sp_out == 16'h00FF, "R1 sp after push", sp_out, 16'h00FF);
        chk(last_data == 16'h1234, "R2 push data", last_data, 16'h1234);
        chk(last_seg == 16'h5A5A, "R2 push segment", last_seg, 16'h5A5A);
        chk(pc_out == 16'hABCD, "R3 pc target", pc_out, 16'hABCD);
        chk(acc_cnt - a0 == 1, "R6 one access call", acc_cnt - a0, 1);
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
        a0 = acc_cnt;
        run_cmd(1'b1, 16'h7777, 16'h8888, 16'h0C0C, cyc);
        chk(cyc == 5, "R5 ret latency", cyc, 5);
        chk(last_we == 1'b0 && last_off == 16'h00FF, "R4 pop offset", last_off, 16'h00FF);
        chk(last_seg == 16'h0C0C, "R4 pop segment", last_seg, 16'h0C0C);
        chk(sp_out == 16'h0100, "R4 sp after pop", sp_out, 16'h0100);
        chk(pc_out == 16'h1234, "R5 pc restored", pc_out, 16'h1234);
        chk(acc_cnt - a0 == 1, "R6 one access ret", acc_cnt - a0, 1);
    endtask

    task automatic t_nested;
        int cyc;
        mem_lat = 3;
        run_cmd(1'b0, 16'h1111, 16'h2000, 16'h0001, cyc);
        chk(cyc == 9, "R7 wait stretches call", cyc, 9);
        run_cmd(1'b0, 16'h2222, 16'h3000, 16'h0001, cyc);
        chk(sp_out == 16'h00FE, "R1 nested sp", sp_out, 16'h00FE);
        chk(pc_out == 16'h3000, "R3 nested pc", pc_out, 16'h3000);
        run_cmd(1'b1, 16'h0, 16'h0, 16'h0001, cyc);
        chk(cyc == 8, "R7 wait stretches ret", cyc, 8);
        chk(pc_out == 16'h2222, "R6 LIFO first", pc_out, 16'h2222);
        run_cmd(1'b1, 16'h0, 16'h0, 16'h0001, cyc);
        chk(pc_out == 16'h1111, "R6 LIFO second", pc_out, 16'h1111);
        chk(sp_out == 16'h0100, "R4 nested sp", sp_out, 16'h0100);
        mem_lat = 0;
    endtask

    task automatic t_wrap;
        int cyc;
        load_sp(16'h0000);
        run_cmd(1'b0, 16'h4242, 16'h0010, 16'h0002, cyc);
        chk(last_off == 16'hFFFF, "R1 wrap offset", last_off, 16'hFFFF);
        chk(sp_out == 16'hFFFF, "R1 wrap sp", sp_out, 16'hFFFF);
        run_cmd(1'b1, 16'h0, 16'h0, 16'h0002, cyc);
        chk(sp_out == 16'h0000, "R4 wrap sp", sp_out, 16'h0000);
        chk(pc_out == 16'h4242, "R5 wrap pc", pc_out, 16'h4242);
    endtask

    task automatic t_busy_ignore;
        int a0, cyc;
        load_sp(16'h0080);
        a0 = acc_cnt;
        @(negedge clk);
        start = 1'b1; op_ret = 1'b0; pc_in = 16'h0A0A; target_in = 16'h0B0B; ss_in = 16'h0003;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; op_ret = 1'b1; pc_in = 16'hDEAD; target_in = 16'hBEEF; ss_in = 16'h0009;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(pc_out == 16'h0B0B, "R9 pc unaffected", pc_out, 16'h0B0B);
        chk(last_data == 16'h0A0A && last_seg == 16'h0003, "R9 data unaffected", last_data, 16'h0A0A);
        repeat (12) @(negedge clk);
        chk(acc_cnt - a0 == 1, "R9 no extra access", acc_cnt - a0, 1);
        chk(sp_out == 16'h007F && !busy, "R9 sp and idle", sp_out, 16'h007F);
    endtask

    initial begin
        foreach (mem[i]) mem[i] = '0;
        t_reset();
        t_call_ret();
        t_nested();
        t_wrap();
        t_busy_ignore();
        report();
    end

endmodule